// File: doc/BRIEF.md
# Two-Half Word Readout Buffer

This block sits behind a serial word receiver. Each time the receiver completes a 32-bit word, it presents the word with a one-cycle write pulse. The buffer stores the word and raises a ready flag. A host with a narrower 16-bit bus then fetches the word in two halves. Each half is requested by holding an active-low read strobe.

An internal half pointer chooses which half appears on the bus. The pointer steps when the strobe is released and wraps back to the first half after the last one. The ready flag drops once the first half has been fetched.

A fresh word always replaces the stored one, even while a read is in progress, and the pointer returns to the first half. A host that is late therefore loses the older word rather than getting a mix of two words. The bus drivers themselves are outside the block. The block supplies the half-word data and an enable that marks when the pins should be driven.

Top module: `hwb_top`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `data_rdy` and `bus_oe` are 0 and `bus_data` is 0. The half pointer starts at the first half.
- R2: A cycle with `wr_valid` high stores `wr_word`. From the next cycle onward `data_rdy` reads 1.
- R3: The first fetch after a store puts word bits [15:0] on `bus_data[15:0]`. These are the serial bits 1 to 16, with serial bit 1 in bus bit 0.
- R4: The second fetch puts word bits [31:16] on `bus_data[15:0]`, which are serial bits 17 to 32. A third fetch wraps and returns bits [15:0] again.
- R5: The strobe's return to high (the trailing edge) advances the pointer. When that fetch was of the first half, the same edge clears `data_rdy`. A fetch of the second half leaves `data_rdy` unchanged.
- R6: One cycle after `rd_n` is sampled low, `bus_oe` is 1 and `bus_data` carries the selected half. One cycle after `rd_n` is sampled high, `bus_oe` is 0 and `bus_data` is 0.
- R7: A store overwrites the buffer whether or not it was read. When the previous word's first half was never fetched, that word is lost and the next fetch returns bits [15:0] of the new word.
- R8: A store resets the pointer to the first half. This holds when the store lands between the two fetches, and when it lands in the same cycle as a trailing strobe edge. In that shared cycle the store wins: `data_rdy` ends at 1 and the next fetch returns bits [15:0] of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle pulse that stores `wr_word` |
| wr_word | input | 32 | Word from the serial receiver; bit 0 is serial bit 1 |
| rd_n | input | 1 | Active-low fetch strobe |
| bus_data | output | 16 | Selected half while enabled, 0 otherwise |
| bus_oe | output | 1 | High when the bus pins should be driven |
| data_rdy | output | 1 | A stored word waits whose first half has not been fetched |

## Verification
A pointer that is stuck or skips a step shows up on the very next fetch, because the wrong half of a known word appears one cycle after the strobe falls. A lost or late reset of the pointer on a store shows up the same way, in the fetch that follows a store made mid-read or in the strobe's release cycle. A ready flag that clears on the wrong fetch, or is overridden when a store coincides with a strobe release, is visible at `data_rdy` in the cycle after that edge. An enable that is held too long shows up as non-zero data or a high `bus_oe` one cycle after release.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  // One-hot view of the strobe phases seen by the store.
  typedef struct packed {
    logic active;    // strobe sampled low this cycle
    logic release_e; // trailing edge: strobe back high after being low
  } strobe_t;
endpackage

// File: rtl/hwb_strobe_sync.sv
module hwb_strobe_sync
  import hwb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rd_n,
  output strobe_t strobe
);
  logic rd_n_q;

  always_ff @(posedge clk) begin
    if (rst) rd_n_q <= 1'b1;
    else     rd_n_q <= rd_n;
  end

  always_comb begin
    strobe.active    = !rd_n;
    strobe.release_e = !rd_n_q && rd_n;
  end
endmodule

// File: rtl/hwb_store.sv
module hwb_store
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int NHALF  = 2,
  localparam int WORD_W = HALF_W * NHALF,
  localparam int PTR_W  = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  strobe_t           strobe,
  output logic [PTR_W-1:0]  ptr,
  output logic [HALF_W-1:0] cur_half,
  output logic              data_rdy
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NHALF - 1);

  logic [HALF_W-1:0] mem [NHALF];

  // Halves are written in parallel; the bus reads one by pointer.
  for (genvar g = 0; g < NHALF; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (wr_valid) mem[g] <= wr_word[g*HALF_W +: HALF_W];
    end
  end

  assign cur_half = mem[ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      data_rdy <= 1'b0;
    end else if (wr_valid) begin
      // store has priority over a coincident strobe release
      ptr      <= '0;
      data_rdy <= 1'b1;
    end else if (strobe.release_e) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      if (ptr == '0) data_rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/hwb_bus_out.sv
module hwb_bus_out
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [HALF_W-1:0] cur_half,
  output logic [HALF_W-1:0] bus_data,
  output logic              bus_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      bus_data <= '0;
    end else begin
      bus_oe   <= strobe.active;
      bus_data <= strobe.active ? cur_half : '0;
    end
  end
endmodule

// File: rtl/hwb_top.sv
module hwb_top
  import hwb_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int NHALF  = 2,
  localparam int WORD_W = HALF_W * NHALF,
  localparam int PTR_W  = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_n,
  output logic [HALF_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              data_rdy
);
  strobe_t           strobe;
  logic [PTR_W-1:0]  ptr;
  logic [HALF_W-1:0] cur_half;

  hwb_strobe_sync u_sync (
    .clk(clk), .rst(rst), .rd_n(rd_n), .strobe(strobe)
  );

  hwb_store #(.HALF_W(HALF_W), .NHALF(NHALF)) u_store (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
    .strobe(strobe), .ptr(ptr), .cur_half(cur_half), .data_rdy(data_rdy)
  );

  hwb_bus_out #(.HALF_W(HALF_W)) u_out (
    .clk(clk), .rst(rst), .strobe(strobe), .cur_half(cur_half),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
  parameter int HALF_W = 16,
  parameter int PTR_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              rd_n,
  input logic [HALF_W-1:0] bus_data,
  input logic              bus_oe,
  input logic              data_rdy,
  input logic [PTR_W-1:0]  ptr
);
  assert_store_sets_R2: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> data_rdy);

  assert_store_rewinds_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> (ptr == '0));

  assert_released_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0));

  assert_enable_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bus_oe == !$past(rd_n)));

  assert_rdy_falls_on_release_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(data_rdy) && !$past(rst)) |-> ($past(rd_n) && !$past(wr_valid)));

  assert_ptr_holds_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_valid) && !rd_n && !$past(rd_n)) |-> $stable(ptr));
endmodule

bind hwb_top hwb_checker #(.HALF_W(HALF_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_n(rd_n),
  .bus_data(bus_data), .bus_oe(bus_oe), .data_rdy(data_rdy), .ptr(ptr)
);

// File: tb/sim_hwb_top.sv
module sim_hwb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        rd_n = 1'b1;
  logic [15:0] bus_data;
  logic        bus_oe;
  logic        data_rdy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hwb_top u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
    .rd_n(rd_n), .bus_data(bus_data), .bus_oe(bus_oe), .data_rdy(data_rdy)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic store(input logic [31:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_word = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // Fetch one half; checks data while enabled and quiet after release.
  task automatic fetch(input string tag, input logic [15:0] exp);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk);
    chk({tag, " R6 oe"}, {31'd0, bus_oe}, 32'd1);
    chk(tag, {16'd0, bus_data}, {16'd0, exp});
    rd_n = 1'b1;
    @(negedge clk);
    chk("R6 released oe", {31'd0, bus_oe}, 32'd0);
    chk("R6 released data", {16'd0, bus_data}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdy in reset", {31'd0, data_rdy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdy", {31'd0, data_rdy}, 32'd0);
    chk("R1 oe", {31'd0, bus_oe}, 32'd0);
    chk("R1 data", {16'd0, bus_data}, 32'd0);

    for (int i = 0; i < 48; i++) begin
      logic [31:0] w;
      w = (32'(i) * 32'h9E3779B9) ^ (32'h1 << (i % 32));
      store(w);
      chk("R2 rdy after store", {31'd0, data_rdy}, 32'd1);
      fetch("R3 first half", w[15:0]);
      chk("R5 rdy cleared", {31'd0, data_rdy}, 32'd0);
      fetch("R4 second half", w[31:16]);
      chk("R5 rdy stays low", {31'd0, data_rdy}, 32'd0);
      fetch("R4 wrap half", w[15:0]);
    end

    // R7: unread word is lost
    store(32'hAAAA_1111);
    store(32'h5555_2222);
    fetch("R7 overwrite first", 16'h2222);
    fetch("R7 overwrite second", 16'h5555);

    // R8: store between the two fetches
    store(32'hCAFE_0001);
    fetch("R8 first", 16'h0001);
    store(32'hBEEF_0002);
    chk("R8 rdy set mid-read", {31'd0, data_rdy}, 32'd1);
    fetch("R8 restart first", 16'h0002);
    fetch("R8 restart second", 16'hBEEF);

    // R8: store in the same cycle as the strobe release
    store(32'h1234_5678);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; wr_valid = 1'b1; wr_word = 32'h9ABC_DEF0;
    @(negedge clk); wr_valid = 1'b0;
    chk("R8 coincident rdy", {31'd0, data_rdy}, 32'd1);
    fetch("R8 coincident first", 16'hDEF0);
    chk("R5 coincident then clear", {31'd0, data_rdy}, 32'd0);
    fetch("R8 coincident second", 16'h9ABC);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule